// File: doc/BRIEF.md
# Multiplexed-Address NOR Flash Read Controller

This controller sits on the host side of a 16-bit NOR flash device whose address is qualified by an active-low address-valid strobe. A user port takes a word address and a request. The controller then produces the device pin sequence and returns the data word with a one-cycle valid pulse.

Two read styles are supported. A single asynchronous read drives the address with the strobe low for one cycle and raises the strobe so the device captures the address. It then holds output enable low until a programmable number of controller cycles has passed since the strobe fell, and only then samples the data bus.

A burst read instead lets the device capture the start address on a rising edge of a generated half-rate device clock while the strobe is low. After a programmable initial latency, counted in device clock rising edges, it collects one sequential word per device clock. Chip enable goes high after the last word to end the burst. The block leaves reset in asynchronous mode with every device control pin inactive.

Top module: `flash_read_ctrl`

## Requirements
- R1: While reset is asserted and after its release, flCeN, flOeN and flAvdN are high, flClk is low, rspValid is low and reqReady is high.
- R2: flWeN is high in every cycle.
- R3: An asynchronous read (reqBurst=0) starts in the cycle after acceptance with one cycle of flCeN=0, flAvdN=0 and flOeN=1 and the request address on flAddr. In the next cycle flAvdN is high and flOeN is low. flOeN never falls unless flAvdN was low in the previous cycle, and flOeN is never low while flCeN is high.
- R4: With the address-strobe cycle counted as cycle 0, an asynchronous read samples flDq at the end of cycle max(accCycles,2). The sampled word appears on rspData with rspValid high in the next cycle, never earlier.
- R5: flAddr holds the request address unchanged for as long as flCeN stays low.
- R6: rspValid is a single-cycle pulse. In the cycle that presents the final word of a request, flCeN and flOeN are already high.
- R7: reqLen holds the burst length minus one (0 means 1 word, 15 means 16 words). Exactly that many words are returned, and no others.
- R8: A burst read (reqBurst=1) holds flAvdN low for two cycles after acceptance with flClk low then high, so the device clock's first rising edge latches the address. flClk then toggles every cycle, giving one device clock per two controller cycles.
- R9: With L = max(burstLat,1), burst word j (from 0) is the flDq value during the flClk-high cycle of the (L+j)-th rising edge after the latching edge. It is returned in order, with rspValid one cycle after that flClk-high cycle.
- R10: When the burst ends, flCeN goes high, and flClk is low whenever flCeN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| accCycles | input | CNT_W | Asynchronous access time in controller cycles |
| burstLat | input | LAT_W | Initial burst latency in device clock edges |
| reqValid | input | 1 | Read request, taken when reqReady is high |
| reqBurst | input | 1 | 1 selects a burst read, 0 a single asynchronous read |
| reqAddr | input | ADDR_W | Word address of the read or burst start |
| reqLen | input | LEN_W | Burst length minus one |
| reqReady | output | 1 | Controller idle and able to accept a request |
| rspValid | output | 1 | One-cycle pulse marking a returned word |
| rspData | output | DATA_W | Returned data word |
| flCeN | output | 1 | Device chip enable, active low |
| flOeN | output | 1 | Device output enable, active low |
| flWeN | output | 1 | Device write enable, held inactive |
| flAvdN | output | 1 | Address-valid strobe, active low |
| flClk | output | 1 | Device clock for burst reads |
| flAddr | output | ADDR_W | Device address bus |
| flDq | input | DATA_W | Device data bus |

## Verification
The flash stub drives a poison value until the access count since the strobe fell has been reached. A controller that samples even one cycle early, or that ignores the two-cycle floor when accCycles is 0, therefore returns a wrong word. The bench also checks the pin pattern relative to the acceptance edge, so a strobe that rises late or output enable asserted together with the strobe shows up as a mismatch.

For bursts, the stub counts device clock edges itself. An off-by-one in the latency, including treating a latency of 0 literally, shifts the whole word sequence. A wrong length decode produces a missing or surplus valid pulse. A burst that leaves chip enable low or the clock running after the final word fails the end-of-transfer check.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LATCH,
    ST_WAIT,
    ST_SAMPLE,
    ST_BADDR,
    ST_BDATA
  } rdState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadAddr;
    logic capture;
    logic clkRun;
  } dpCtl_t;

endpackage

// File: rtl/frc_ctrl.sv
module frc_ctrl
  import flash_rd_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LAT_W = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqBurst,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [CNT_W-1:0] accCycles,
  input  logic [LAT_W-1:0] burstLat,
  input  logic             flClk,
  output logic             reqReady,
  output logic             ceN,
  output logic             oeN,
  output logic             avdN,
  output logic             weN,
  output dpCtl_t           ctl
);

  localparam int ACC_W = CNT_W + 1;
  localparam int RISE_W = LAT_W + 1;
  localparam logic [ACC_W-1:0] MIN_ACC = ACC_W'(2);

  rdState_e state, nxt;
  logic [CNT_W-1:0] cnt;
  logic [LAT_W-1:0] riseCnt;
  logic [LEN_W-1:0] wordsLeft;

  logic [ACC_W-1:0]  accEff, cntNext;
  logic [RISE_W-1:0] latEff, riseNext;
  logic              beatHit;

  assign accEff   = ({1'b0, accCycles} < MIN_ACC) ? MIN_ACC : {1'b0, accCycles};
  assign cntNext  = {1'b0, cnt} + ACC_W'(1);
  assign latEff   = (burstLat == '0) ? RISE_W'(1) : {1'b0, burstLat};
  assign riseNext = {1'b0, riseCnt} + RISE_W'(1);
  assign beatHit  = flClk && (riseNext >= latEff);

  always_comb begin
    nxt = state;
    ctl = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadAddr = 1'b1;
          nxt = reqBurst ? ST_BADDR : ST_ADDR;
        end
      end
      ST_ADDR:  nxt = ST_LATCH;
      ST_LATCH,
      ST_WAIT:  nxt = (cntNext >= accEff) ? ST_SAMPLE : ST_WAIT;
      ST_SAMPLE: begin
        ctl.capture = 1'b1;
        nxt = ST_IDLE;
      end
      ST_BADDR: begin
        ctl.clkRun = 1'b1;
        if (flClk) nxt = ST_BDATA;
      end
      ST_BDATA: begin
        ctl.clkRun = 1'b1;
        if (beatHit) begin
          ctl.capture = 1'b1;
          if (wordsLeft == '0) nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      riseCnt   <= '0;
      wordsLeft <= '0;
    end else begin
      state <= nxt;
      case (state)
        ST_IDLE: begin
          cnt     <= '0;
          riseCnt <= '0;
          if (reqValid) wordsLeft <= reqLen;
        end
        ST_ADDR: cnt <= CNT_W'(1);
        ST_LATCH,
        ST_WAIT: cnt <= cntNext[CNT_W-1:0];
        ST_BDATA: begin
          if (flClk && !beatHit) riseCnt <= riseNext[LAT_W-1:0];
          if (beatHit && wordsLeft != '0) wordsLeft <= wordsLeft - LEN_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign ceN      = (state == ST_IDLE);
  assign avdN     = !(state == ST_ADDR || state == ST_BADDR);
  assign oeN      = !(state == ST_LATCH || state == ST_WAIT ||
                      state == ST_SAMPLE || state == ST_BDATA);
  assign weN      = 1'b1;

  assert_oe_within_ce_R3: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !ceN);

  assert_oe_after_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oeN) |-> $past(!avdN));

  assert_clk_edge_under_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BADDR && flClk) |-> !avdN);

endmodule

// File: rtl/frc_datapath.sv
module frc_datapath
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] flDq,
  output logic [ADDR_W-1:0] flAddr,
  output logic              flClk,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flAddr   <= '0;
      flClk    <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (ctl.loadAddr) flAddr <= reqAddr;
      flClk    <= ctl.clkRun ? ~flClk : 1'b0;
      rspValid <= ctl.capture;
      if (ctl.capture) rspData <= flDq;
    end
  end

  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/flash_read_ctrl.sv
module flash_read_ctrl
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  parameter int LAT_W  = 4,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  accCycles,
  input  logic [LAT_W-1:0]  burstLat,
  input  logic              reqValid,
  input  logic              reqBurst,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic              flAvdN,
  output logic              flClk,
  output logic [ADDR_W-1:0] flAddr,
  input  logic [DATA_W-1:0] flDq
);

  dpCtl_t ctl;

  frc_ctrl #(.CNT_W(CNT_W), .LAT_W(LAT_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqBurst(reqBurst), .reqLen(reqLen),
    .accCycles(accCycles), .burstLat(burstLat), .flClk(flClk),
    .reqReady(reqReady), .ceN(flCeN), .oeN(flOeN), .avdN(flAvdN),
    .weN(flWeN), .ctl(ctl)
  );

  frc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .flDq(flDq),
    .flAddr(flAddr), .flClk(flClk), .rspValid(rspValid), .rspData(rspData)
  );

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!flCeN && $past(!flCeN)) |-> $stable(flAddr));

  assert_clk_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    flCeN |-> !flClk);

endmodule

// File: tb/tb_flash_read_ctrl.sv
module tb_flash_read_ctrl;

  localparam int AW = 25;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] accCycles = 6'd3;
  logic [3:0] burstLat = 4'd2;
  logic reqValid = 1'b0, reqBurst = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0] reqLen = '0;
  logic reqReady, rspValid, flCeN, flOeN, flWeN, flAvdN, flClk;
  logic [DW-1:0] rspData, flDq;
  logic [AW-1:0] flAddr;

  always #4 clk = ~clk;

  flash_read_ctrl dut (
    .clk(clk), .rstN(rstN), .accCycles(accCycles), .burstLat(burstLat),
    .reqValid(reqValid), .reqBurst(reqBurst), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN), .flAvdN(flAvdN),
    .flClk(flClk), .flAddr(flAddr), .flDq(flDq)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C ^ {7'b0, a[24:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural flash stub, updated away from the controller's edge
  int age = 0, kEdge = 0;
  bit bAct = 0, prevClk = 0;
  logic [AW-1:0] aAddr = '0, bAddr = '0;

  function automatic int latE();
    return (burstLat == 0) ? 1 : int'(burstLat);
  endfunction

  always @(negedge clk) begin
    if (flCeN) begin
      bAct = 0;
      age  = 0;
    end else begin
      if (!flAvdN) begin aAddr = flAddr; age = 0; end
      else age++;
      if (flClk && !prevClk) begin
        if (!flAvdN) begin bAddr = flAddr; kEdge = 0; bAct = 1; end
        else if (bAct) kEdge++;
      end
    end
    prevClk = flClk;
  end

  always @* begin
    if (!flCeN && !flOeN) begin
      if (bAct) flDq = (kEdge >= latE()) ? pat(bAddr + AW'(kEdge - latE())) : 16'hBAD1;
      else      flDq = (age >= int'(accCycles)) ? pat(aAddr) : 16'hBAD0;
    end else flDq = 16'hBAD2;
  end

  // reference model: expected response cycles and words
  int expCyc[$];
  logic [DW-1:0] expDat[$];
  int curP = 0;
  bit curBurst = 0, curActive = 0;
  logic [AW-1:0] curAddr = '0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(flWeN == 1'b1, "R2", "write enable", flWeN, 1);
      if (curActive) begin
        int rel;
        rel = cyc - curP;
        if (!flCeN) chk(flAddr == curAddr, "R5", "address held", flAddr, curAddr);
        if (rel == 0) begin
          chk(!flCeN && !flAvdN && flOeN, "R3", "strobe cycle ce/avd/oe",
              {flCeN, flAvdN, flOeN}, 3'b001);
          chk(flClk == 1'b0, "R8", "clock low in first strobe cycle", flClk, 0);
        end
        if (rel == 1 && !curBurst)
          chk(flAvdN && !flOeN, "R3", "strobe high, oe low", {flAvdN, flOeN}, 2'b10);
        if (rel == 1 && curBurst)
          chk(!flAvdN && flClk, "R8", "latch edge under strobe", {flAvdN, flClk}, 2'b01);
        if (rel == 2 && curBurst)
          chk(flAvdN && !flClk && !flOeN, "R8", "after latch",
              {flAvdN, flClk, flOeN}, 3'b100);
      end
      if (expCyc.size() != 0 && expCyc[0] == cyc) begin
        chk(rspValid == 1'b1, curBurst ? "R9" : "R4", "valid timing", rspValid, 1);
        chk(rspData == expDat[0], curBurst ? "R9" : "R4", "data word", rspData, expDat[0]);
        void'(expCyc.pop_front());
        void'(expDat.pop_front());
        if (expCyc.size() == 0) begin
          chk(flCeN && flOeN, "R6", "enables high at final word", {flCeN, flOeN}, 2'b11);
          chk(!flClk, "R10", "clock stopped", flClk, 0);
          curActive = 0;
        end
      end else if (rspValid) begin
        chk(1'b0, "R7", "unexpected valid pulse", 1, 0);
      end
      if (flCeN) chk(!flClk, "R10", "clock low in standby", flClk, 0);
    end
  end

  task automatic doRead(input logic [AW-1:0] a, input bit burst, input int lenM1);
    int p;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqBurst = burst; reqAddr = a; reqLen = 4'(lenM1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    p = cyc;
    curP = p; curAddr = a; curBurst = burst; curActive = 1;
    if (!burst) begin
      int s;
      s = (accCycles < 2) ? 2 : int'(accCycles);
      expCyc.push_back(p + s + 1);
      expDat.push_back(pat(a));
    end else begin
      for (int j = 0; j <= lenM1; j++) begin
        expCyc.push_back(p + 2 + 2 * (latE() + j));
        expDat.push_back(pat(a + AW'(j)));
      end
    end
    wait (!curActive);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(flCeN && flOeN && flAvdN && !flClk && !rspValid && reqReady, "R1",
        "in reset", {flCeN, flOeN, flAvdN, flClk, rspValid, reqReady}, 6'b111001);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(flCeN && flOeN && flAvdN && !flClk && !rspValid && reqReady, "R1",
        "after reset", {flCeN, flOeN, flAvdN, flClk, rspValid, reqReady}, 6'b111001);

    accCycles = 6'd3; doRead(25'h0001234, 0, 0);         // R4 nominal
    accCycles = 6'd7; doRead(25'h1ABCDEF, 0, 0);         // R4 long access
    accCycles = 6'd0; doRead(25'h0000042, 0, 0);         // R4 floor of two
    accCycles = 6'd2; doRead(25'h0FFFFFF, 0, 0);         // R4 boundary
    burstLat = 4'd0;  doRead(25'h0000100, 1, 0);         // R7 single word, R9 latency 0
    burstLat = 4'd2;  doRead(25'h0012340, 1, 3);         // R9 four words
    burstLat = 4'd3;  doRead(25'h1FFFFF0, 1, 15);        // R7 sixteen words
    burstLat = 4'd1;  doRead(25'h0000200, 1, 1);         // R10 back-to-back
    accCycles = 6'd4; doRead(25'h0000203, 0, 0);         // async after burst

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule